// File: doc/BRIEF.md
# Shared Interrupt Link Steering Router

This block collects eight level-sensitive shared interrupt links and steers each of them onto one of sixteen legacy IRQ output lines. Each link is fed by several request lines from the devices that share it; the link counts as active while any of those lines is high. A configuration port holds one byte-wide steering register per link: a disable flag and a four-bit target IRQ number.

A link drives its target line only when it is enabled and the target is a legal IRQ number. Targets outside a fixed allow-mask behave exactly like a disabled link. Every output line is the OR of all links steered to it, so several links can share one line. The outputs are registered. When a live link is re-steered, its assertion moves from the old line to the new one in a single clock edge.

Top module: `link_irq_router`

## Requirements
- R1: After reset every steering register reads 0x80 (disabled) and `irq_o` is all zero.
- R2: A write to link select 1..8 stores the write data ANDed with 0x8F. A read returns the stored byte unchanged, so bits 6:4 always read 0. The read data follows the select combinationally.
- R3: Link select values 0 and 9..15 are not links. Writes to them change no register, and reads of them return 0x00.
- R4: A link drives output line N only when its bit 7 (disable) is 0 and N = bits 3:0 lies in the allow-mask 0xDEF8 (IRQ 3-7, 9-12, 14, 15). Targets 0, 1, 2, 8 and 13, or a set disable bit, drive no line.
- R5: Link k (select k+1) is active while any of its request lines `link_req_i[k*REQS_PER_LINK +: REQS_PER_LINK]` is high. Its line stays asserted until the last of those lines is released.
- R6: Output line N is the OR of every active, valid link whose target is N. Two links on one line keep it asserted until both are released.
- R7: Re-steering an active link deasserts the old line and asserts the new one on the same clock edge, with no cycle in which both or neither are driven. Re-steering it to a reserved target drops it from every line.
- R8: A request level present at clock edge k appears on `irq_o` after edge k. A write accepted at edge k is reflected on `irq_o` after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_req_i | input | NUM_LINKS*REQS_PER_LINK | Request lines, REQS_PER_LINK per link, link 0 lowest |
| cfg_we_i | input | 1 | Write strobe for the steering registers |
| cfg_sel_i | input | 4 | Link select; 1..8 address links 0..7 |
| cfg_wdata_i | input | 8 | Write data |
| cfg_rdata_o | output | 8 | Read data of the selected link, combinational |
| irq_o | output | NUM_IRQS | Registered IRQ output lines |

## Verification
The hardest case to reach is a routing change that lands while a link is active. In that case the old and new lines must swap on the very same edge. The bench holds a link's request high and rewrites its register. It samples `irq_o` once between the write edge and the next edge, and again after that next edge, so the old-only and new-only states are both seen. Sharing is reached from two directions: several request lines on one link, and two links steered to one line. Each source is released on its own and the line is checked after each release.

// File: rtl/link_router_pkg.sv
`timescale 1ns/1ps
package link_router_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned FIELD_W = 4;
  localparam int unsigned DIS_BIT = 7;
  localparam logic [REG_W-1:0] KEEP_MASK = 8'h8F;
  localparam logic [REG_W-1:0] RESET_VAL = 8'h80;

  typedef logic [REG_W-1:0] link_reg_t;

  function automatic logic [FIELD_W-1:0] target_of(input link_reg_t r);
    return r[FIELD_W-1:0];
  endfunction

  function automatic logic is_off(input link_reg_t r);
    return r[DIS_BIT];
  endfunction
endpackage

// File: rtl/link_cfg_regs.sv
`timescale 1ns/1ps
module link_cfg_regs
  import link_router_pkg::*;
#(
  parameter int unsigned NUM_LINKS = 8,
  parameter int unsigned SEL_W     = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we_i,
  input  logic [SEL_W-1:0]            sel_i,
  input  logic [REG_W-1:0]            wdata_i,
  output logic [REG_W-1:0]            rdata_o,
  output link_reg_t [NUM_LINKS-1:0]   regs_o
);
  logic              sel_ok;
  logic [REG_W-1:0]  wmasked;
  link_reg_t [NUM_LINKS-1:0] regs_q;

  assign sel_ok  = (sel_i != '0) && (sel_i <= SEL_W'(NUM_LINKS));
  assign wmasked = wdata_i & KEEP_MASK;

  for (genvar i = 0; i < NUM_LINKS; i++) begin : g_reg
    logic hit;
    assign hit = we_i && (sel_i == SEL_W'(i + 1)) && (wmasked != regs_q[i]);
    always_ff @(posedge clk) begin
      if (rst) begin
        regs_q[i] <= RESET_VAL;
      end else if (hit) begin
        regs_q[i] <= wmasked;
      end
    end

    // R1
    reset_val_chk: assert property (@(posedge clk) rst |=> (regs_q[i] == RESET_VAL))
      else $error("steering register %0d not at reset value", i);

    // R2
    unused_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (regs_q[i][6:4] == 3'b000))
      else $error("steering register %0d holds bits 6:4", i);
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_LINKS; i++) begin
      if (sel_i == SEL_W'(i + 1)) rdata_o = regs_q[i];
    end
  end

  assign regs_o = regs_q;

  // R3
  bad_sel_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (we_i && !sel_ok) |=> $stable(regs_q))
    else $error("write to a non-link select changed a register");
endmodule

// File: rtl/link_req_merge.sv
`timescale 1ns/1ps
module link_req_merge #(
  parameter int unsigned NUM_LINKS     = 8,
  parameter int unsigned REQS_PER_LINK = 4,
  localparam int unsigned REQ_W = NUM_LINKS * REQS_PER_LINK
) (
  input  logic [REQ_W-1:0]     req_i,
  output logic [NUM_LINKS-1:0] active_o
);
  for (genvar i = 0; i < NUM_LINKS; i++) begin : g_or
    assign active_o[i] = |req_i[i*REQS_PER_LINK +: REQS_PER_LINK];
  end
endmodule

// File: rtl/link_valid_dec.sv
`timescale 1ns/1ps
module link_valid_dec
  import link_router_pkg::*;
#(
  parameter int unsigned NUM_LINKS = 8,
  parameter int unsigned NUM_IRQS  = 16,
  parameter logic [NUM_IRQS-1:0] ALLOW_MASK = 16'hDEF8
) (
  input  link_reg_t [NUM_LINKS-1:0]            regs_i,
  output logic [NUM_LINKS-1:0][NUM_IRQS-1:0]   tgt_o
);
  for (genvar i = 0; i < NUM_LINKS; i++) begin : g_link
    logic [FIELD_W-1:0] tgt;
    logic               legal;
    assign tgt   = target_of(regs_i[i]);
    assign legal = !is_off(regs_i[i]) && (32'(tgt) < NUM_IRQS) && ALLOW_MASK[tgt];
    for (genvar n = 0; n < NUM_IRQS; n++) begin : g_line
      assign tgt_o[i][n] = legal && (32'(tgt) == n);
    end
  end
endmodule

// File: rtl/irq_xbar.sv
`timescale 1ns/1ps
module irq_xbar #(
  parameter int unsigned NUM_LINKS = 8,
  parameter int unsigned NUM_IRQS  = 16
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [NUM_LINKS-1:0]               active_i,
  input  logic [NUM_LINKS-1:0][NUM_IRQS-1:0] tgt_i,
  output logic [NUM_IRQS-1:0]                irq_o
);
  logic [NUM_IRQS-1:0] irq_d, irq_q;

  for (genvar n = 0; n < NUM_IRQS; n++) begin : g_line
    logic [NUM_LINKS-1:0] drv;
    for (genvar i = 0; i < NUM_LINKS; i++) begin : g_src
      assign drv[i] = active_i[i] && tgt_i[i][n];
    end
    assign irq_d[n] = |drv;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= '0;
    else     irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  // R7: one link selects at most one line
  for (genvar i = 0; i < NUM_LINKS; i++) begin : g_chk
    one_target_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(tgt_i[i]))
      else $error("link %0d decodes to more than one line", i);
  end
endmodule

// File: rtl/link_irq_router.sv
`timescale 1ns/1ps
module link_irq_router
  import link_router_pkg::*;
#(
  parameter int unsigned NUM_LINKS     = 8,
  parameter int unsigned REQS_PER_LINK = 4,
  parameter int unsigned NUM_IRQS      = 16,
  parameter logic [NUM_IRQS-1:0] ALLOW_MASK = 16'hDEF8,
  localparam int unsigned SEL_W = $clog2(NUM_LINKS + 1),
  localparam int unsigned REQ_W = NUM_LINKS * REQS_PER_LINK
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [REQ_W-1:0]    link_req_i,
  input  logic                cfg_we_i,
  input  logic [SEL_W-1:0]    cfg_sel_i,
  input  logic [REG_W-1:0]    cfg_wdata_i,
  output logic [REG_W-1:0]    cfg_rdata_o,
  output logic [NUM_IRQS-1:0] irq_o
);
  link_reg_t [NUM_LINKS-1:0]             regs;
  logic [NUM_LINKS-1:0]                  active;
  logic [NUM_LINKS-1:0][NUM_IRQS-1:0]    tgt;

  link_cfg_regs #(.NUM_LINKS(NUM_LINKS), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst(rst), .we_i(cfg_we_i), .sel_i(cfg_sel_i),
    .wdata_i(cfg_wdata_i), .rdata_o(cfg_rdata_o), .regs_o(regs)
  );

  link_req_merge #(.NUM_LINKS(NUM_LINKS), .REQS_PER_LINK(REQS_PER_LINK)) u_merge (
    .req_i(link_req_i), .active_o(active)
  );

  link_valid_dec #(.NUM_LINKS(NUM_LINKS), .NUM_IRQS(NUM_IRQS), .ALLOW_MASK(ALLOW_MASK)) u_dec (
    .regs_i(regs), .tgt_o(tgt)
  );

  irq_xbar #(.NUM_LINKS(NUM_LINKS), .NUM_IRQS(NUM_IRQS)) u_xbar (
    .clk(clk), .rst(rst), .active_i(active), .tgt_i(tgt), .irq_o(irq_o)
  );

  // R4
  reserved_line_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ((irq_o & ~ALLOW_MASK) == '0))
    else $error("reserved IRQ line driven");

  // R8
  irq_needs_request_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_o != '0) |-> $past(active != '0))
    else $error("IRQ line asserted with no active link on the previous edge");
endmodule

// File: tb/link_irq_router_tb_top.sv
`timescale 1ns/1ps
module link_irq_router_tb_top;
  localparam int NL = 8;
  localparam int RP = 4;
  localparam int NI = 16;
  localparam logic [15:0] LEGAL = 16'hDEF8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NL*RP-1:0] req = '0;
  logic we = 1'b0;
  logic [3:0] sel = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [NI-1:0] irq;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [7:0] model [1:8];

  always #10 clk = ~clk;

  link_irq_router dut_i (
    .clk(clk), .rst(rst), .link_req_i(req), .cfg_we_i(we), .cfg_sel_i(sel),
    .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [NI-1:0] exp_irq();
    logic [NI-1:0] e = '0;
    for (int p = 1; p <= NL; p++) begin
      logic act = |req[(p-1)*RP +: RP];
      if (act && !model[p][7] && LEGAL[model[p][3:0]]) e[model[p][3:0]] = 1'b1;
    end
    return e;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] s, input logic [7:0] d);
    @(negedge clk); we = 1'b1; sel = s; wdata = d;
    @(negedge clk); we = 1'b0;
    if (s >= 1 && s <= NL) model[s] = d & 8'h8F;
  endtask

  task automatic rd(input logic [3:0] s, output logic [7:0] d);
    @(negedge clk); sel = s; #1; d = rdata;
  endtask

  task automatic set_req(input int link, input int line, input logic v);
    @(negedge clk); req[link*RP + line] = v;
  endtask

  task automatic settle(); @(negedge clk); endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 irq after reset", 32'(irq), 32'h0);
    for (int p = 1; p <= NL; p++) begin
      rd(4'(p), d); chk("R1 reg reset value", 32'(d), 32'h80);
    end
  endtask

  task automatic t_regrw();
    logic [7:0] d;
    wr(4'd3, 8'hFF); rd(4'd3, d); chk("R2 masked write 0xFF", 32'(d), 32'h8F);
    wr(4'd3, 8'h75); rd(4'd3, d); chk("R2 masked write 0x75", 32'(d), 32'h05);
    wr(4'd3, 8'h80); rd(4'd3, d); chk("R2 write back disabled", 32'(d), 32'h80);
  endtask

  task automatic t_bad_sel();
    logic [7:0] d;
    wr(4'd0, 8'h05); wr(4'd9, 8'h06); wr(4'd15, 8'h07);
    for (int p = 1; p <= NL; p++) begin
      rd(4'(p), d); chk("R3 link regs untouched", 32'(d), 32'(model[p]));
    end
    rd(4'd0, d);  chk("R3 read select 0", 32'(d), 32'h0);
    rd(4'd9, d);  chk("R3 read select 9", 32'(d), 32'h0);
  endtask

  task automatic t_all_targets();
    set_req(0, 1, 1'b1);
    for (int n = 0; n < NI; n++) begin
      wr(4'd1, 8'(n)); settle();
      chk($sformatf("R4 target %0d", n), 32'(irq), LEGAL[n] ? (32'h1 << n) : 32'h0);
    end
    wr(4'd1, 8'h85); settle();
    chk("R4 disable flag suppresses", 32'(irq), 32'h0);
    wr(4'd1, 8'h05); settle();
    chk("R4 re-enabled", 32'(irq), 32'h20);
    set_req(0, 1, 1'b0); settle();
    chk("R4 release", 32'(irq), 32'h0);
  endtask

  task automatic t_multi_req();
    wr(4'd4, 8'h0A);
    set_req(3, 0, 1'b1); set_req(3, 2, 1'b1); settle();
    chk("R5 two requesters", 32'(irq), 32'h400);
    set_req(3, 0, 1'b0); settle();
    chk("R5 one requester left", 32'(irq), 32'h400);
    set_req(3, 2, 1'b0); settle();
    chk("R5 last released", 32'(irq), 32'h0);
  endtask

  task automatic t_two_links();
    wr(4'd5, 8'h0B); wr(4'd6, 8'h0B); wr(4'd7, 8'h0C);
    set_req(4, 3, 1'b1); set_req(5, 0, 1'b1); set_req(6, 1, 1'b1); settle();
    chk("R6 shared and separate lines", 32'(irq), 32'h1800);
    set_req(4, 3, 1'b0); settle();
    chk("R6 first sharer released", 32'(irq), 32'h1800);
    set_req(5, 0, 1'b0); settle();
    chk("R6 second sharer released", 32'(irq), 32'h1000);
    set_req(6, 1, 1'b0); settle();
    chk("R6 model agrees", 32'(irq), 32'(exp_irq()));
  endtask

  task automatic t_reroute();
    wr(4'd8, 8'h03);
    set_req(7, 2, 1'b1); settle();
    chk("R7 before reroute", 32'(irq), 32'h8);
    wr(4'd8, 8'h0E);
    chk("R8 old line held one edge after write", 32'(irq), 32'h8);
    settle();
    chk("R7 moved to new line", 32'(irq), 32'h4000);
    wr(4'd8, 8'h0D); settle();
    chk("R7 rerouted to reserved", 32'(irq), 32'h0);
    set_req(7, 2, 1'b0); settle();
  endtask

  task automatic t_timing();
    wr(4'd2, 8'h09); settle();
    @(negedge clk); req[1*RP] = 1'b1; #1;
    chk("R8 not before edge", 32'(irq), 32'h0);
    @(negedge clk);
    chk("R8 after one edge", 32'(irq), 32'h200);
    req[1*RP] = 1'b0; @(negedge clk);
    chk("R8 release after one edge", 32'(irq), 32'h0);
  endtask

  initial begin
    for (int p = 1; p <= NL; p++) model[p] = 8'h80;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regrw();
    t_bad_sel();
    t_all_targets();
    t_multi_req();
    t_two_links();
    t_reroute();
    t_timing();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule